// File: doc/BRIEF.md
# Rotating-Priority In-Service Resolver

This block decides which of eight interrupt levels is presented to a processor. It receives a vector of pending requests that has already been latched and masked upstream. It keeps a record of the levels currently being serviced, and it holds a pointer that names the lowest-priority level. Priority runs upward, modulo eight, from the level just above that pointer. The highest-priority pending level is reported as a 3-bit code. An interrupt flag goes high when that level is allowed to pre-empt the work already in service.

Software steers the block through a one-cycle command strobe that carries three control bits (rotate, select, end-of-service) and a 3-bit level field. Depending on the encoding, a command retires an in-service level, moves the lowest-priority pointer, or does both at once. A separate strobe reports that an acknowledge sequence has finished. Two mode inputs change the behaviour. In the automatic end-of-service mode, an acknowledge retires its level straight away. In the special mask mode, levels already in service stop blocking other levels.

Top module: `irq_priority_core`

## Requirements
- R1: On a synchronous active-low reset, the in-service vector clears and the lowest-priority pointer becomes level 7, so that level 0 has the highest priority.
- R2: Levels are ranked starting at pointer+1 (mod 8), which has rank 0. While any request is pending, `win_lvl_o` gives the binary level of the pending request with the lowest rank. When no request is pending, its value carries no meaning.
- R3: Outside special mask mode, `int_o` is 1 exactly when a request is pending and either no level is in service or the winner's rank is strictly lower than the rank of the best-ranked in-service level. A level that is already in service therefore cannot interrupt itself.
- R4: An acknowledge strobe with automatic mode off sets the in-service bit of the current winner. An acknowledge while no request is pending changes nothing.
- R5: Command {rotate,select,eos}=001 clears the in-service bit with the lowest rank. If no bit is set, it does nothing.
- R6: Command 011 clears the in-service bit at the level given in the level field.
- R7: Command 101 clears the in-service bit with the lowest rank and then moves the pointer to that level. If no bit is set, it changes nothing.
- R8: Command 110 loads the pointer from the level field and leaves the in-service vector unchanged.
- R9: Command 111 clears the in-service bit at the level field and loads the pointer with that level.
- R10: With automatic mode on, an acknowledge leaves the in-service vector unchanged. Command 100 turns on rotate-on-acknowledge and command 000 turns it off. While rotate-on-acknowledge is on, an acknowledge in automatic mode loads the pointer with the acknowledged level.
- R11: In special mask mode, `int_o` is 1 whenever any request is pending. The clearing done by commands 001 and 101 considers only the in-service bits whose mask bit is 0.
- R12: Command 010 changes neither the in-service vector nor the priority order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 8 | Pending requests, already masked |
| mask_i | input | 8 | Mask vector, 1 = level masked |
| ack_i | input | 1 | Acknowledge sequence finished (one cycle) |
| cmd_valid_i | input | 1 | Command strobe (one cycle) |
| cmd_rot_i | input | 1 | Command rotate bit |
| cmd_sel_i | input | 1 | Command select-level bit |
| cmd_eos_i | input | 1 | Command end-of-service bit |
| cmd_lvl_i | input | 3 | Command level field |
| auto_eos_i | input | 1 | Automatic end-of-service mode |
| smm_i | input | 1 | Special mask mode |
| int_o | output | 1 | Interrupt request to the processor |
| win_lvl_o | output | 3 | Binary code of the winning pending level |
| isr_o | output | 8 | In-service vector |

## Verification
The assertions assume that the acknowledge strobe and the command strobe never arrive in the same cycle. They also assume that an acknowledge arrives only while `int_o` is high or while no request is pending, which is how a processor answers a raised interrupt. The stimulus follows these rules directly. The bench tracks its own copy of the interrupt flag. When that copy is low, it turns an acknowledge step into one with no requests, and it never issues a command on an acknowledge step. The request vector is always formed from the mask, as random requests ANDed with the inverted mask, so that the upstream masking contract holds.

// File: rtl/irqp_pkg.sv
// Package: shared command encoding for the rotating priority resolver.
// Assumes the command is presented as the concatenation {rotate, select, eos}.
package irqp_pkg;
    typedef enum logic [2:0] {
        CK_ROT_ACK_OFF = 3'b000,
        CK_EOS_TOP     = 3'b001,
        CK_NOP         = 3'b010,
        CK_EOS_AT      = 3'b011,
        CK_ROT_ACK_ON  = 3'b100,
        CK_EOS_TOP_ROT = 3'b101,
        CK_SET_LOW     = 3'b110,
        CK_EOS_AT_ROT  = 3'b111
    } cmd_kind_e;
endpackage

// File: rtl/irqp_prio_pick.sv
// Module: finds the best-ranked set bit of a vector under a rotating order.
// The rank of level l is (l - low_ptr - 1) mod N. Assumes N is a power of two.
module irqp_prio_pick #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec_i,
    input  logic [W-1:0] low_ptr_i,
    output logic         any_o,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rank_o
);
    logic [W-1:0] base;
    logic [N-1:0] rot;

    // Level with rank zero.
    assign base = low_ptr_i + W'(1);

    // Reorder the vector so that bit k holds the level of rank k.
    for (genvar k = 0; k < N; k++) begin : g_rot
        localparam logic [W-1:0] KOFF = W'(k);
        assign rot[k] = vec_i[KOFF + base];
    end

    // Priority encode the lowest rank that is set.
    always_comb begin
        rank_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (rot[i]) rank_o = W'(i);
        end
    end

    // Convert the rank back into an absolute level.
    assign any_o = |vec_i;
    assign lvl_o = rank_o + base;
endmodule

// File: rtl/irqp_cmd_decode.sv
// Module: turns the three command bits into action flags.
// Assumes a command lasts exactly one cycle; the flags are zero when no command is valid.
module irqp_cmd_decode
    import irqp_pkg::*;
(
    input  logic valid_i,
    input  logic rot_i,
    input  logic sel_i,
    input  logic eos_i,
    output logic clr_top_o,
    output logic clr_at_o,
    output logic rot_clr_o,
    output logic set_low_o,
    output logic ack_rot_on_o,
    output logic ack_rot_off_o
);
    cmd_kind_e kind;

    assign kind = cmd_kind_e'({rot_i, sel_i, eos_i});

    // Map each encoding to its actions.
    always_comb begin
        clr_top_o     = 1'b0;
        clr_at_o      = 1'b0;
        rot_clr_o     = 1'b0;
        set_low_o     = 1'b0;
        ack_rot_on_o  = 1'b0;
        ack_rot_off_o = 1'b0;
        if (valid_i) begin
            unique case (kind)
                CK_ROT_ACK_OFF: ack_rot_off_o = 1'b1;
                CK_EOS_TOP:     clr_top_o = 1'b1;
                CK_NOP:         ;
                CK_EOS_AT:      clr_at_o = 1'b1;
                CK_ROT_ACK_ON:  ack_rot_on_o = 1'b1;
                CK_EOS_TOP_ROT: begin clr_top_o = 1'b1; rot_clr_o = 1'b1; end
                CK_SET_LOW:     set_low_o = 1'b1;
                CK_EOS_AT_ROT:  begin clr_at_o = 1'b1; rot_clr_o = 1'b1; end
                default:        ;
            endcase
        end
    end
endmodule

// File: rtl/irqp_state.sv
// Module: holds the in-service vector, the lowest-priority pointer and the rotate-on-acknowledge mode.
// Assumes that a command and an acknowledge never come in the same cycle; if they do, the command wins.
module irqp_state #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ack_i,
    input  logic         req_any_i,
    input  logic [W-1:0] win_lvl_i,
    input  logic         auto_eos_i,
    input  logic         cmd_valid_i,
    input  logic [W-1:0] cmd_lvl_i,
    input  logic         clr_top_i,
    input  logic         clr_at_i,
    input  logic         rot_clr_i,
    input  logic         set_low_i,
    input  logic         ack_rot_on_i,
    input  logic         ack_rot_off_i,
    input  logic         top_valid_i,
    input  logic [W-1:0] top_lvl_i,
    output logic [N-1:0] isr_o,
    output logic [W-1:0] low_ptr_o
);
    logic [N-1:0] isr_q, isr_n;
    logic [W-1:0] low_q, low_n;
    logic         ack_rot_q, ack_rot_n;

    // Next-state rules for commands and acknowledges.
    always_comb begin
        isr_n     = isr_q;
        low_n     = low_q;
        ack_rot_n = ack_rot_q;
        if (cmd_valid_i) begin
            if (clr_top_i && top_valid_i) begin
                isr_n[top_lvl_i] = 1'b0;
                if (rot_clr_i) low_n = top_lvl_i;
            end
            if (clr_at_i) begin
                isr_n[cmd_lvl_i] = 1'b0;
                if (rot_clr_i) low_n = cmd_lvl_i;
            end
            if (set_low_i)     low_n = cmd_lvl_i;
            if (ack_rot_on_i)  ack_rot_n = 1'b1;
            if (ack_rot_off_i) ack_rot_n = 1'b0;
        end else if (ack_i && req_any_i) begin
            if (!auto_eos_i)    isr_n[win_lvl_i] = 1'b1;
            else if (ack_rot_q) low_n = win_lvl_i;
        end
    end

    // State registers with synchronous reset; level N-1 starts as the lowest priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q     <= '0;
            low_q     <= W'(N - 1);
            ack_rot_q <= 1'b0;
        end else begin
            isr_q     <= isr_n;
            low_q     <= low_n;
            ack_rot_q <= ack_rot_n;
        end
    end

    assign isr_o     = isr_q;
    assign low_ptr_o = low_q;

    assert_ack_sets_isr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && req_any_i && !auto_eos_i && !cmd_valid_i) |=> isr_q[$past(win_lvl_i)]);
    assert_eos_at_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && clr_at_i) |=> !isr_q[$past(cmd_lvl_i)]);
    assert_set_low_keeps_isr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && set_low_i) |=> ($stable(isr_q) && low_q == $past(cmd_lvl_i)));
    assert_auto_ack_keeps_isr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && auto_eos_i && !cmd_valid_i) |=> $stable(isr_q));
endmodule

// File: rtl/irq_priority_core.sv
// Module: top of the eight-level rotating priority resolver.
// Assumes req_i is already masked and that ack_i comes only while int_o is high or no request is pending.
module irq_priority_core #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] mask_i,
    input  logic         ack_i,
    input  logic         cmd_valid_i,
    input  logic         cmd_rot_i,
    input  logic         cmd_sel_i,
    input  logic         cmd_eos_i,
    input  logic [W-1:0] cmd_lvl_i,
    input  logic         auto_eos_i,
    input  logic         smm_i,
    output logic         int_o,
    output logic [W-1:0] win_lvl_o,
    output logic [N-1:0] isr_o
);
    logic         req_any, isr_any, top_any;
    logic [W-1:0] win_rank, isr_lvl, isr_rank, top_lvl, top_rank;
    logic [W-1:0] low_ptr;
    logic [N-1:0] top_cand;
    logic         clr_top, clr_at, rot_clr, set_low, ack_rot_on, ack_rot_off;

    // Winner among the pending requests.
    irqp_prio_pick #(.N(N), .W(W)) u_pick_req (
        .vec_i(req_i), .low_ptr_i(low_ptr),
        .any_o(req_any), .lvl_o(win_lvl_o), .rank_o(win_rank));

    // Best-ranked in-service level, used for blocking.
    irqp_prio_pick #(.N(N), .W(W)) u_pick_isr (
        .vec_i(isr_o), .low_ptr_i(low_ptr),
        .any_o(isr_any), .lvl_o(isr_lvl), .rank_o(isr_rank));

    // In special mask mode, masked in-service bits are not candidates for clearing.
    assign top_cand = smm_i ? (isr_o & ~mask_i) : isr_o;

    // Target of a clear-top command.
    irqp_prio_pick #(.N(N), .W(W)) u_pick_top (
        .vec_i(top_cand), .low_ptr_i(low_ptr),
        .any_o(top_any), .lvl_o(top_lvl), .rank_o(top_rank));

    irqp_cmd_decode u_dec (
        .valid_i(cmd_valid_i), .rot_i(cmd_rot_i), .sel_i(cmd_sel_i), .eos_i(cmd_eos_i),
        .clr_top_o(clr_top), .clr_at_o(clr_at), .rot_clr_o(rot_clr),
        .set_low_o(set_low), .ack_rot_on_o(ack_rot_on), .ack_rot_off_o(ack_rot_off));

    irqp_state #(.N(N), .W(W)) u_state (
        .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .req_any_i(req_any),
        .win_lvl_i(win_lvl_o), .auto_eos_i(auto_eos_i), .cmd_valid_i(cmd_valid_i),
        .cmd_lvl_i(cmd_lvl_i), .clr_top_i(clr_top), .clr_at_i(clr_at),
        .rot_clr_i(rot_clr), .set_low_i(set_low), .ack_rot_on_i(ack_rot_on),
        .ack_rot_off_i(ack_rot_off), .top_valid_i(top_any), .top_lvl_i(top_lvl),
        .isr_o(isr_o), .low_ptr_o(low_ptr));

    // Interrupt decision: special mask mode ignores in-service blocking; otherwise a strictly better rank is needed.
    assign int_o = req_any && (smm_i || !isr_any || (win_rank < isr_rank));

    assert_no_self_preempt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!smm_i && int_o) |-> !isr_o[win_lvl_o]);
    assert_ack_only_when_int_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && req_any) |-> (int_o && !cmd_valid_i));
    assert_top_clear_one_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_eos_i && !cmd_sel_i && !smm_i) |=>
        ($countones(isr_o) + (($past(isr_o) != '0) ? 1 : 0) == $countones($past(isr_o))));
    assert_smm_keeps_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_eos_i && !cmd_sel_i && smm_i) |=>
        ((isr_o & $past(mask_i)) == $past(isr_o & mask_i)));
endmodule

// File: tb/irq_priority_core_bench.sv
module irq_priority_core_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req, mask;
    logic       ack, cmd_v, c_rot, c_sel, c_eos, aeos, smm;
    logic [2:0] c_lvl;
    logic       int_o;
    logic [2:0] win;
    logic [7:0] isr;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] m_isr;
    logic [2:0] m_low;
    logic       m_rot;
    string      prev_tag;

    always #5 clk = ~clk;

    irq_priority_core u_irq_priority_core (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask), .ack_i(ack),
        .cmd_valid_i(cmd_v), .cmd_rot_i(c_rot), .cmd_sel_i(c_sel), .cmd_eos_i(c_eos),
        .cmd_lvl_i(c_lvl), .auto_eos_i(aeos), .smm_i(smm),
        .int_o(int_o), .win_lvl_o(win), .isr_o(isr));

    // Returns {found, level} for the best-ranked set bit of v.
    function automatic logic [3:0] pick(input logic [7:0] v, input logic [2:0] low);
        for (int k = 0; k < 8; k++) begin
            logic [2:0] l;
            l = low + 3'(k + 1);
            if (v[l]) return {1'b1, l};
        end
        return 4'b0;
    endfunction

    function automatic logic [2:0] rank(input logic [2:0] l, input logic [2:0] low);
        return l - low - 3'd1;
    endfunction

    function automatic logic model_int(input logic [7:0] r, input logic s);
        logic [3:0] w, t;
        w = pick(r, m_low);
        t = pick(m_isr, m_low);
        return w[3] && (s || !t[3] || rank(w[2:0], m_low) < rank(t[2:0], m_low));
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check combinational outputs and the state, update the model.
    task automatic step(input logic [7:0] r, input logic [7:0] m, input logic a,
                        input logic cv, input logic [2:0] cbits, input logic [2:0] lv,
                        input logic ae, input logic s);
        logic [3:0] w, t;
        string tag;
        @(negedge clk);
        req = r; mask = m; ack = a; cmd_v = cv;
        {c_rot, c_sel, c_eos} = cbits; c_lvl = lv; aeos = ae; smm = s;
        #1;
        check(prev_tag, int'(isr), int'(m_isr), "isr_o");
        w = pick(r, m_low);
        if (w[3]) check("R2", int'(win), int'(w[2:0]), "win_lvl_o");
        check(s ? "R11" : "R3", int'(int_o), int'(model_int(r, s)), "int_o");
        tag = "R12";
        if (cv) begin
            t = pick(s ? (m_isr & ~m) : m_isr, m_low);
            case (cbits)
                3'b000: begin m_rot = 1'b0; tag = "R10"; end
                3'b100: begin m_rot = 1'b1; tag = "R10"; end
                3'b001: begin if (t[3]) m_isr[t[2:0]] = 1'b0; tag = s ? "R11" : "R5"; end
                3'b101: begin
                    if (t[3]) begin m_isr[t[2:0]] = 1'b0; m_low = t[2:0]; end
                    tag = s ? "R11" : "R7";
                end
                3'b011: begin m_isr[lv] = 1'b0; tag = "R6"; end
                3'b110: begin m_low = lv; tag = "R8"; end
                3'b111: begin m_isr[lv] = 1'b0; m_low = lv; tag = "R9"; end
                default: tag = "R12";
            endcase
        end else if (a && w[3]) begin
            if (!ae) begin m_isr[w[2:0]] = 1'b1; tag = "R4"; end
            else begin
                if (m_rot) m_low = w[2:0];
                tag = "R10";
            end
        end else if (a) begin
            tag = "R4";
        end
        prev_tag = tag;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; req = '0; mask = '0; ack = 0; cmd_v = 0;
        c_rot = 0; c_sel = 0; c_eos = 0; c_lvl = '0; aeos = 0; smm = 0;
        m_isr = '0; m_low = 3'd7; m_rot = 1'b0; prev_tag = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        req = 8'hFF;
        #1;
        // R1: reset state, level 0 highest.
        check("R1", int'(isr), 0, "isr_o after reset");
        check("R1", int'(win), 0, "win_lvl_o after reset");
        check("R1", int'(int_o), 1, "int_o after reset");
        req = 8'h80;
        #1;
        check("R1", int'(win), 7, "win_lvl_o lowest level");

        // Sweep every pointer position and every request pattern with nothing in service (R2, R3, R8).
        for (int lp = 0; lp < 8; lp++) begin
            step(8'h00, 8'h00, 1'b0, 1'b1, 3'b110, 3'(lp), 1'b0, 1'b0);
            for (int r = 1; r < 256; r++)
                step(8'(r), 8'h00, 1'b0, 1'b0, 3'b000, 3'd0, 1'b0, 1'b0);
        end

        // Directed R9 then R7: specific rotate, acknowledge, rotate on top clear.
        step(8'h00, 8'h00, 1'b0, 1'b1, 3'b111, 3'd4, 1'b0, 1'b0);
        step(8'h20, 8'h00, 1'b1, 1'b0, 3'b000, 3'd0, 1'b0, 1'b0);
        step(8'h00, 8'h00, 1'b0, 1'b1, 3'b101, 3'd0, 1'b0, 1'b0);
        step(8'h00, 8'h00, 1'b0, 1'b1, 3'b010, 3'd3, 1'b0, 1'b0);

        // Pseudo-random operation mix across all modes.
        begin
            logic ae_v, s_v;
            ae_v = 1'b0;
            s_v = 1'b0;
            for (int i = 0; i < 6000; i++) begin
                logic [7:0] m, r;
                int op;
                if (i % 64 == 0) ae_v = ($urandom % 3) == 0;
                if (i % 32 == 0) s_v = ($urandom % 3) == 0;
                m = 8'($urandom) & 8'($urandom);
                r = 8'($urandom) & ~m;
                op = int'($urandom % 16);
                if (op < 7) begin
                    if (!model_int(r, s_v)) r = 8'h00;
                    step(r, m, 1'b1, 1'b0, 3'b000, 3'd0, ae_v, s_v);
                end else if (op < 13) begin
                    step(r, m, 1'b0, 1'b1, 3'($urandom), 3'($urandom), ae_v, s_v);
                end else begin
                    step(r, m, 1'b0, 1'b0, 3'b000, 3'd0, ae_v, s_v);
                end
            end
        end
        step(8'h00, 8'h00, 1'b0, 1'b0, 3'b000, 3'd0, 1'b0, 1'b0);
        summary();
        $finish;
    end
endmodule